// File: doc/BRIEF.md
# Chained Transfer Descriptor Walker

This block drives one data channel through a chain of transfer descriptors held in memory. Each descriptor names a target word address, a length in words, the address of the descriptor that follows it, and two control flags. When software raises the channel enable, the block fetches the first descriptor from the address in its base register. It then cuts the descriptor's length into bursts of at most `BURST_MAX` words and hands each burst to a transfer engine. When a descriptor is used up, the block follows its link to the next descriptor.

Interrupts come only from the descriptors. A descriptor that carries the host-interrupt flag sets one sticky status bit when it finishes. A descriptor that carries the end-of-chain flag sets a second sticky status bit when it finishes, and the channel then stops by itself. Software clears the status bits by writing ones to them. Software can also stop the channel by dropping the enable, or restart it from the base descriptor with a channel reset. The fill-level output shows how many words of the current descriptor are still to be moved.

Top module: `dma_chain_seq`

## Requirements
- R1: While reset is low and just after it, `run`, `desc_req`, `xfer_req`, `irq`, `stat` and `fill_lvl` are all zero.
- R2: A rising edge on `en` while the channel is idle starts a fetch at `base_addr`. `desc_req` and `desc_addr` stay steady until `desc_vld` is high on a clock edge.
- R3: The descriptor word is laid out as follows: bits [AW-1:0] are the target, [AW+LW-1:AW] the length, [2AW+LW-1:AW+LW] the link, bit 2AW+LW the host-interrupt flag and bit 2AW+LW+1 the end-of-chain flag. With the defaults these are 15:0, 27:16, 43:28, 44 and 45. Once a descriptor is loaded, `fill_lvl` equals its length.
- R4: Each burst request carries `xfer_addr` equal to the current target and `xfer_len` equal to the smaller of the remaining length and `BURST_MAX`. The request holds steady until `xfer_ack`. The next burst is issued only after `xfer_done`, and by then the target has advanced and the fill level has dropped by the burst size.
- R5: When a descriptor without the end-of-chain flag finishes, the next fetch uses its link field.
- R6: A descriptor of length zero finishes without issuing any burst request.
- R7: A finishing descriptor with the host-interrupt flag sets `stat[0]`. A descriptor without the flag leaves `stat[0]` unchanged.
- R8: A finishing descriptor with the end-of-chain flag sets `stat[1]` and drops `run`. No further request follows while `en` stays high.
- R9: The status bits stay set until a one is written to the matching `stat_clr` bit. A new set in the same cycle as a clear wins. `irq` is high whenever any status bit is set.
- R10: When `en` drops while a burst is pending, that burst is still acknowledged and completed. No new request follows, and `run` then falls.
- R11: A `chan_rst` pulse abandons the current descriptor and clears the fill level. If `en` is high, the channel fetches again from `base_addr` on the next cycle and replays the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| en | input | 1 | Channel enable; rising edge activates |
| chan_rst | input | 1 | Channel reset pulse |
| base_addr | input | ADDR_W | Address of the first descriptor |
| stat_clr | input | 2 | Write-one-to-clear strobes for the status bits |
| desc_req | output | 1 | Descriptor read request |
| desc_addr | output | ADDR_W | Descriptor read address |
| desc_vld | input | 1 | Descriptor data valid |
| desc_data | input | 2*ADDR_W+LEN_W+2 | Descriptor word |
| xfer_req | output | 1 | Burst request |
| xfer_addr | output | ADDR_W | Burst start word address |
| xfer_len | output | $clog2(BURST_MAX+1) | Burst length in words |
| xfer_ack | input | 1 | Burst request accepted |
| xfer_done | input | 1 | Accepted burst finished |
| fill_lvl | output | LEN_W | Words left in the current descriptor |
| stat | output | 2 | Sticky status: [0] flagged descriptor done, [1] end of chain |
| irq | output | 1 | Level interrupt |
| run | output | 1 | Channel busy |

## Verification
Some properties are checked on every cycle. The assertions hold the request stability of both handshakes and keep burst length bounded by the fill level. They also check that the fill level never grows except on a descriptor load, that status bits stay set until cleared, that no request is raised while the enable is low, that the channel is idle right after an end-of-chain finish, and that a channel reset with the enable high restarts at the base address. Other behaviour needs whole chains, so only the bench scenarios can show it. These cover the exact order of fetch addresses and bursts across a chain, the zero-length descriptor being skipped, which status bit each flag sets, completion of a burst that was pending when the enable fell, and the replay from the base after a reset in the middle of a chain.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_EVAL,
    S_ISSUE,
    S_WAIT
  } seq_state_e;

  // Burst size for a given remaining word count and burst cap.
  function automatic int unsigned burst_of(input int unsigned remaining,
                                           input int unsigned cap);
    return (remaining < cap) ? remaining : cap;
  endfunction

endpackage

// File: rtl/dma_seq_cursor.sv
module dma_seq_cursor
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 12,
  parameter int BURST_MAX = 8,
  parameter int BLEN_W    = $clog2(BURST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] ld_tgt,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [ADDR_W-1:0] ld_next,
  input  logic              ld_hirq,
  input  logic              ld_last,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  remain,
  output logic [BLEN_W-1:0] burst,
  output logic [ADDR_W-1:0] next_ptr,
  output logic              hirq,
  output logic              last
);

  assign burst = BLEN_W'(burst_of(32'(remain), BURST_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cur_addr <= '0;
      remain   <= '0;
      next_ptr <= '0;
      hirq     <= 1'b0;
      last     <= 1'b0;
    end else if (load) begin
      cur_addr <= ld_tgt;
      remain   <= ld_len;
      next_ptr <= ld_next;
      hirq     <= ld_hirq;
      last     <= ld_last;
    end else if (step) begin
      cur_addr <= cur_addr + ADDR_W'(burst);
      remain   <= remain - LEN_W'(burst);
    end
  end

  // R4: a completed burst always moves a nonzero amount
  a_r4_step_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> burst != '0);

  // R3: the remaining count only grows when a descriptor is loaded
  a_r3_fill_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr) |=> remain <= $past(remain));

endmodule

// File: rtl/dma_seq_status.sv
module dma_seq_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_hirq,
  input  logic       set_end,
  input  logic [1:0] clr,
  output logic [1:0] stat,
  output logic       irq
);

  logic [1:0] stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr) | {set_end, set_hirq};
  end

  assign stat = stat_q;
  assign irq  = |stat_q;

  // R9: status bits hold until written with a one
  a_r9_sticky_hirq: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[0] && !clr[0]) |=> stat_q[0]);
  a_r9_sticky_end: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[1] && !clr[1]) |=> stat_q[1]);
  // R9: a clear without a concurrent set empties the bit
  a_r9_clear_hirq: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[0] && !set_hirq) |=> !stat_q[0]);

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 12,
  parameter int BURST_MAX = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        chan_rst,
  input  logic [ADDR_W-1:0]           base_addr,
  input  logic [1:0]                  stat_clr,
  output logic                        desc_req,
  output logic [ADDR_W-1:0]           desc_addr,
  input  logic                        desc_vld,
  input  logic [2*ADDR_W+LEN_W+1:0]   desc_data,
  output logic                        xfer_req,
  output logic [ADDR_W-1:0]           xfer_addr,
  output logic [$clog2(BURST_MAX+1)-1:0] xfer_len,
  input  logic                        xfer_ack,
  input  logic                        xfer_done,
  output logic [LEN_W-1:0]            fill_lvl,
  output logic [1:0]                  stat,
  output logic                        irq,
  output logic                        run
);

  localparam int BLEN_W   = $clog2(BURST_MAX + 1);
  localparam int LEN_LO   = ADDR_W;
  localparam int NEXT_LO  = ADDR_W + LEN_W;
  localparam int HIRQ_BIT = 2 * ADDR_W + LEN_W;
  localparam int LAST_BIT = HIRQ_BIT + 1;

  seq_state_e        state;
  logic              en_q;
  logic [ADDR_W-1:0] ptr;

  logic [ADDR_W-1:0] cur_addr, next_ptr;
  logic [LEN_W-1:0]  remain;
  logic [BLEN_W-1:0] burst;
  logic              cur_hirq, cur_last;

  // Named internal events
  logic ev_start, ev_desc_load, ev_burst_done, ev_desc_fin, ev_list_end;

  assign ev_start      = en && !en_q;
  assign ev_desc_load  = !chan_rst && state == S_FETCH && en && desc_vld;
  assign ev_burst_done = !chan_rst && state == S_WAIT && xfer_done;
  assign ev_desc_fin   = !chan_rst && state == S_EVAL && remain == '0;
  assign ev_list_end   = ev_desc_fin && cur_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      en_q  <= 1'b0;
      ptr   <= '0;
    end else begin
      en_q <= en;
      if (chan_rst) begin
        state <= en ? S_FETCH : S_IDLE;
        ptr   <= base_addr;
      end else begin
        unique case (state)
          S_IDLE: if (ev_start) begin
            state <= S_FETCH;
            ptr   <= base_addr;
          end
          S_FETCH: begin
            if (!en)          state <= S_IDLE;
            else if (desc_vld) state <= S_EVAL;
          end
          S_EVAL: begin
            if (remain == '0) begin
              if (cur_last || !en) state <= S_IDLE;
              else begin
                state <= S_FETCH;
                ptr   <= next_ptr;
              end
            end else if (!en) state <= S_IDLE;
            else              state <= S_ISSUE;
          end
          S_ISSUE: if (xfer_ack)  state <= S_WAIT;
          S_WAIT:  if (xfer_done) state <= S_EVAL;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  dma_seq_cursor #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_MAX(BURST_MAX), .BLEN_W(BLEN_W)
  ) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (chan_rst),
    .load     (ev_desc_load),
    .step     (ev_burst_done),
    .ld_tgt   (desc_data[ADDR_W-1:0]),
    .ld_len   (desc_data[NEXT_LO-1:LEN_LO]),
    .ld_next  (desc_data[HIRQ_BIT-1:NEXT_LO]),
    .ld_hirq  (desc_data[HIRQ_BIT]),
    .ld_last  (desc_data[LAST_BIT]),
    .cur_addr (cur_addr),
    .remain   (remain),
    .burst    (burst),
    .next_ptr (next_ptr),
    .hirq     (cur_hirq),
    .last     (cur_last)
  );

  dma_seq_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_hirq (ev_desc_fin && cur_hirq),
    .set_end  (ev_list_end),
    .clr      (stat_clr),
    .stat     (stat),
    .irq      (irq)
  );

  assign desc_req  = state == S_FETCH;
  assign desc_addr = ptr;
  assign xfer_req  = state == S_ISSUE;
  assign xfer_addr = cur_addr;
  assign xfer_len  = burst;
  assign fill_lvl  = remain;
  assign run       = state != S_IDLE;

  // R2: descriptor request holds its address until data arrives
  a_r2_desc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_req && !desc_vld && en && !chan_rst) |=> (desc_req && $stable(desc_addr)));

  // R4: burst request holds until acknowledged
  a_r4_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack && !chan_rst) |=>
      (xfer_req && $stable(xfer_addr) && $stable(xfer_len)));

  // R4: burst length is nonzero and never exceeds what is left
  a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (xfer_len != '0 && 32'(xfer_len) <= 32'(fill_lvl)));

  // R8: end of chain leaves the channel idle
  a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_list_end |=> !run);

  // R10: no new burst request is raised while the enable is low
  a_r10_no_new_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !xfer_req && !chan_rst) |=> !xfer_req);

  // R11: reset with enable high refetches from the base address
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_rst && en) |=> (desc_req && desc_addr == $past(base_addr) && fill_lvl == '0));

endmodule

// File: tb/dma_chain_seq_bench.sv
`timescale 1ns/1ps
module dma_chain_seq_bench;

  localparam int AW  = 16;
  localparam int LW  = 12;
  localparam int BM  = 8;
  localparam int BLW = $clog2(BM + 1);
  localparam int DW  = 2 * AW + LW + 2;

  // Expected results of the main chain (base at 0)
  localparam int N_BURST = 5;
  localparam int EXP_ADDR [N_BURST] = '{'h100, 'h108, 'h110, 'h200, 'h400};
  localparam int EXP_LEN  [N_BURST] = '{8, 8, 4, 5, 8};
  localparam int N_FET = 4;
  localparam int EXP_FET  [N_FET]   = '{0, 3, 5, 6};

  logic clk = 1'b0;
  logic rst_n, en, chan_rst;
  logic [AW-1:0] base_addr;
  logic [1:0] stat_clr;
  logic desc_req, desc_vld;
  logic [AW-1:0] desc_addr;
  logic [DW-1:0] desc_data;
  logic xfer_req, xfer_ack, xfer_done;
  logic [AW-1:0] xfer_addr;
  logic [BLW-1:0] xfer_len;
  logic [LW-1:0] fill_lvl;
  logic [1:0] stat;
  logic irq, run;

  always #2.5 clk = ~clk;

  dma_chain_seq #(.ADDR_W(AW), .LEN_W(LW), .BURST_MAX(BM)) u_dma_chain_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .chan_rst(chan_rst), .base_addr(base_addr),
    .stat_clr(stat_clr), .desc_req(desc_req), .desc_addr(desc_addr),
    .desc_vld(desc_vld), .desc_data(desc_data), .xfer_req(xfer_req),
    .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_ack(xfer_ack),
    .xfer_done(xfer_done), .fill_lvl(fill_lvl), .stat(stat), .irq(irq), .run(run)
  );

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] mem [8];
  logic hold;
  int done_cnt;
  int rec_n, fet_n;
  int rec_addr [32];
  int rec_len  [32];
  int fet_addr [32];

  function automatic logic [DW-1:0] mkd(input logic last, input logic hirq,
                                        input int nxt, input int len, input int tgt);
    return {last, hirq, AW'(nxt), LW'(len), AW'(tgt)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!run) break;
    end
  endtask

  task automatic wait_req();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (xfer_req) break;
    end
  endtask

  task automatic clear_logs();
    rec_n = 0;
    fet_n = 0;
  endtask

  // Memory and transfer engine model, acting at the falling edge
  initial begin
    desc_vld = 1'b0; xfer_ack = 1'b0; xfer_done = 1'b0; desc_data = '0;
    done_cnt = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        desc_vld = 1'b0; xfer_ack = 1'b0; xfer_done = 1'b0; done_cnt = 0;
      end else begin
        xfer_done = 1'b0;
        if (done_cnt > 0) begin
          done_cnt--;
          if (done_cnt == 0) xfer_done = 1'b1;
        end
        if (desc_vld) desc_vld = 1'b0;
        else if (desc_req) begin
          desc_vld = 1'b1;
          desc_data = mem[desc_addr[2:0]];
          fet_addr[fet_n] = int'(desc_addr);
          fet_n++;
        end
        if (xfer_ack) xfer_ack = 1'b0;
        else if (xfer_req && !hold) begin
          xfer_ack = 1'b1;
          rec_addr[rec_n] = int'(xfer_addr);
          rec_len[rec_n]  = int'(xfer_len);
          rec_n++;
          done_cnt = 2;
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; chan_rst = 1'b0; base_addr = '0; stat_clr = '0;
    hold = 1'b0; rec_n = 0; fet_n = 0;
    mem[0] = mkd(1'b0, 1'b1, 3, 20, 'h100);
    mem[1] = mkd(1'b0, 1'b0, 2, 12, 'h600);
    mem[2] = mkd(1'b1, 1'b0, 0, 2,  'h700);
    mem[3] = mkd(1'b0, 1'b0, 5, 5,  'h200);
    mem[4] = mkd(1'b1, 1'b0, 0, 1,  'h000);
    mem[5] = mkd(1'b0, 1'b1, 6, 0,  'h300);
    mem[6] = mkd(1'b1, 1'b0, 1, 8,  'h400);
    mem[7] = mkd(1'b1, 1'b0, 0, 3,  'h500);

    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 run in reset", run, 0);
    chk("R1 stat in reset", {irq, stat}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 requests after reset", {desc_req, xfer_req}, 0);
    chk("R1 fill after reset", fill_lvl, 0);

    // Main chain walked against the expected table (R2 R4 R5 R6 R7 R8)
    clear_logs();
    en = 1'b1;
    @(negedge clk);
    wait_idle();
    chk("R5 fetch count", fet_n, N_FET);
    for (int i = 0; i < N_FET; i++) chk("R5 fetch address", fet_addr[i], EXP_FET[i]);
    chk("R6 burst count (zero-length skipped)", rec_n, N_BURST);
    for (int i = 0; i < N_BURST; i++) begin
      chk("R4 burst address", rec_addr[i], EXP_ADDR[i]);
      chk("R4 burst length", rec_len[i], EXP_LEN[i]);
    end
    chk("R7 R8 status after chain", stat, 2'b11);
    chk("R9 irq with status set", irq, 1);
    chk("R8 run after chain", run, 0);
    repeat (10) @(negedge clk);
    chk("R8 no restart while enable high", rec_n + fet_n, N_BURST + N_FET);

    // R9: write-one-to-clear
    stat_clr = 2'b01;
    @(negedge clk);
    stat_clr = 2'b00;
    chk("R9 clear bit0 only", stat, 2'b10);
    chk("R9 irq with bit1 left", irq, 1);
    stat_clr = 2'b10;
    @(negedge clk);
    stat_clr = 2'b00;
    chk("R9 both cleared", {irq, stat}, 0);

    // R2 R8 R7: other base, end flag only
    en = 1'b0; base_addr = 7; clear_logs();
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    wait_idle();
    chk("R2 fetch from base register", fet_addr[0], 7);
    chk("R4 single short burst", {rec_n[7:0], rec_addr[0][15:0], rec_len[0][7:0]}, {8'd1, 16'h500, 8'd3});
    chk("R8 end-only status, R7 hirq untouched", stat, 2'b10);
    stat_clr = 2'b11;
    @(negedge clk);
    stat_clr = 2'b00;

    // R3 R10: fill level after load, disable with a burst pending
    en = 1'b0; base_addr = 0; clear_logs(); hold = 1'b1;
    @(negedge clk);
    en = 1'b1;
    wait_req();
    chk("R3 fill level equals base length", fill_lvl, 20);
    chk("R4 first request", {xfer_addr, 4'(xfer_len)}, {16'h100, 4'd8});
    en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 request held after disable", {xfer_req, xfer_addr}, {1'b1, 16'h100});
    hold = 1'b0;
    wait_idle();
    chk("R10 pending burst completed", rec_n, 1);
    chk("R10 fill after completed burst", fill_lvl, 12);
    chk("R10 channel idle", run, 0);
    chk("R7 no status from partial", stat, 0);

    // R11: channel reset mid-chain replays from base
    clear_logs();
    @(negedge clk);
    en = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (rec_n == 2) break;
    end
    hold = 1'b1;
    wait_req();
    chk("R4 third burst pending", {xfer_addr, 4'(xfer_len)}, {16'h110, 4'd4});
    clear_logs();
    chan_rst = 1'b1;
    @(negedge clk);
    chan_rst = 1'b0;
    chk("R11 refetch at base", {desc_req, desc_addr}, {1'b1, 16'h0});
    chk("R11 fill discarded", fill_lvl, 0);
    @(negedge clk);
    hold = 1'b0;
    wait_idle();
    chk("R11 replay burst count", rec_n, N_BURST);
    chk("R11 replay first burst", {rec_addr[0][15:0], rec_len[0][7:0]}, {16'h100, 8'd8});
    chk("R11 replay fetch order", fet_addr[1], 3);
    chk("R8 R7 status after replay", stat, 2'b11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule